// File: doc/BRIEF.md
# Per-Pin Edge Event Detector

This block watches a set of serially captured input pins and reports edges on them. Pins are grouped eight to a bank, up to eight banks. Each time the serial engine finishes a transfer it presents the complete captured input vector together with a one-cycle strobe. The block compares the new vector with the one it kept from the previous strobe. Every pin whose edge matches its configured kind sets a sticky status bit. A single interrupt output is high while any status bit in any bank is set.

Software reaches the block over a small register bus with byte and halfword writes and combinational read data. Each bank has a 16-bit configuration word that holds a 2-bit edge selector per pin. Each bank also has an 8-bit status byte whose bits are cleared by writing ones. An interrupt handler reads the status bytes and clears what it has served. Because edges are judged only between strobes, a pin that toggles and returns within one transfer period produces no event.

Top module: `pin_edge_evt`

## Requirements
- R1: After a synchronous active-low reset, every configuration word reads 0, every status byte reads 0 and `irq_out` is 0.
- R2: For pin b of a bank, configuration bits 2b+1:2b select the edge kind. Bit 2b enables rising edges (0 to 1) and bit 2b+1 enables falling edges (1 to 0). 11 detects both kinds and 00 detects none.
- R3: The configuration word of bank k sits at address 0x10+2k. A halfword write at that even address loads all 16 bits. A byte write at the even address loads bits 7:0 only, and a byte write at the odd address 0x11+2k loads bits 15:8 only, in both cases from `bus_wdata[7:0]`. A halfword write at an odd configuration address is ignored. A halfword read at the even address returns the word. A byte read returns the addressed byte in bits 7:0.
- R4: The status byte of bank k sits at address 0x20+k, with bit b for pin b. A byte write there clears every status bit whose `bus_wdata` bit is 1 and leaves the bits written 0 unchanged, so 0xFF clears the whole bank.
- R5: Edges are judged only between successive captures marked by `cap_vld`. Changes on `cap_data` without the strobe have no effect. A status bit set by a capture reads back in the cycle after the strobe edge.
- R6: The first capture after reset only records the snapshot and sets no status bit, whatever its value.
- R7: When a capture sets a status bit in the same cycle as a write that clears it, the bit ends up set.
- R8: `irq_out` is 1 exactly when at least one status bit of any bank is 1. It follows the status in the same cycle.
- R9: Writing a configuration word, including writing it to 0, does not clear status bits that are already set.
- R10: Input `cap_data[i]` is pin i, which belongs to bank i/8 at bit i%8.
- R11: A halfword write at a status address is ignored. A write outside the configuration and status ranges changes nothing, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_vld | input | 1 | One-cycle strobe: a new captured vector is on `cap_data` |
| cap_data | input | NBANKS*8 | Captured input pin levels, pin i on bit i |
| bus_wr | input | 1 | Register write strobe |
| bus_hw | input | 1 | 1 for a halfword access, 0 for a byte access |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` and `bus_hw` |
| irq_out | output | 1 | Summary interrupt, OR of all status bits |

## Verification
A wrong snapshot or a priming flag stuck in the wrong state appears at the ports as an extra or missing status bit. That bit can be read on the bus, and it changes `irq_out` in the cycle right after the next capture strobe. A status bit that clears without a write, or sets without a capture, changes `irq_out` and the status read in the following cycle. A decode error shows in the next read of the wrongly touched configuration or status address. The stimulus therefore pairs each capture with reads of banks that are both configured and unconfigured. It also places a clear in the same cycle as a set, and it reconfigures pins while their status bits are set.

// File: rtl/ped_pkg.sv
// Shared constants and types for the per-pin edge event detector.
// Assumes at most eight banks so the configuration and status ranges do not overlap.
package ped_pkg;
    localparam int PINS_PER_BANK = 8;
    localparam int CFG_W         = 2 * PINS_PER_BANK;
    localparam int CFG_BASE      = 'h10;
    localparam int STS_BASE      = 'h20;

    // Two-bit edge selector of one pin, bit 0 rising, bit 1 falling.
    typedef struct packed {
        logic fall_en;
        logic rise_en;
    } pin_sel_t;

    // Which register kind a bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STS  = 2'd2
    } reg_sel_t;
endpackage

// File: rtl/ped_snapshot.sv
// Keeps the previous captured pin vector and produces rise/fall pulses per pin.
// Assumes cap_vld is a single-cycle strobe; the first strobe after reset only primes.
module ped_snapshot #(
    parameter int NPINS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_vld,
    input  logic [NPINS-1:0] cap_data,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);
    logic [NPINS-1:0] prev_q;
    logic             primed_q;
    logic             judge;

    // Store the latest captured vector and note that a reference exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (cap_vld) begin
            prev_q   <= cap_data;
            primed_q <= 1'b1;
        end
    end

    assign judge = cap_vld & primed_q;

    // Compare new vector against the stored one only on a primed strobe.
    always_comb begin
        rise = '0;
        fall = '0;
        if (judge) begin
            rise = cap_data & ~prev_q;
            fall = ~cap_data & prev_q;
        end
    end
endmodule

// File: rtl/ped_bus_dec.sv
// Decodes the register bus into per-bank write enables and a read selector.
// Assumes byte data on bus_wdata[7:0]; halfword config writes must be even-aligned.
module ped_bus_dec #(
    parameter int NBANKS = 8,
    parameter int ADDR_W = 6,
    localparam int BW    = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              bus_wr,
    input  logic              bus_hw,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NBANKS-1:0] cfg_we_lo,
    output logic [NBANKS-1:0] cfg_we_hi,
    output logic [NBANKS-1:0] sts_we,
    output ped_pkg::reg_sel_t rd_sel,
    output logic [BW-1:0]     rd_bank,
    output logic              rd_hi
);
    import ped_pkg::*;

    localparam logic [ADDR_W-1:0] CFG_LO  = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(CFG_BASE + 2 * NBANKS);
    localparam logic [ADDR_W-1:0] STS_LO  = ADDR_W'(STS_BASE);
    localparam logic [ADDR_W-1:0] STS_END = ADDR_W'(STS_BASE + NBANKS);

    logic              cfg_hit;
    logic              sts_hit;
    logic [ADDR_W-1:0] cfg_off;
    logic [ADDR_W-1:0] sts_off;
    logic [BW-1:0]     cfg_bank;
    logic [BW-1:0]     sts_bank;

    // Range checks and bank index extraction.
    always_comb begin
        cfg_hit  = (bus_addr >= CFG_LO) && (bus_addr < CFG_END);
        sts_hit  = (bus_addr >= STS_LO) && (bus_addr < STS_END);
        cfg_off  = bus_addr - CFG_LO;
        sts_off  = bus_addr - STS_LO;
        cfg_bank = BW'(cfg_off >> 1);
        sts_bank = BW'(sts_off);
    end

    // Per-bank write enables; halfword to status or odd config is dropped.
    always_comb begin
        for (int k = 0; k < NBANKS; k++) begin
            cfg_we_lo[k] = bus_wr && cfg_hit && (cfg_bank == BW'(k)) && !cfg_off[0];
            cfg_we_hi[k] = bus_wr && cfg_hit && (cfg_bank == BW'(k))
                           && (bus_hw ? !cfg_off[0] : cfg_off[0]);
            sts_we[k]    = bus_wr && !bus_hw && sts_hit && (sts_bank == BW'(k));
        end
    end

    // Read selector for the top-level data mux.
    always_comb begin
        rd_sel  = SEL_NONE;
        rd_bank = '0;
        rd_hi   = 1'b0;
        if (cfg_hit) begin
            rd_sel  = SEL_CFG;
            rd_bank = cfg_bank;
            rd_hi   = cfg_off[0];
        end else if (sts_hit) begin
            rd_sel  = SEL_STS;
            rd_bank = sts_bank;
        end
    end
endmodule

// File: rtl/ped_bank.sv
// One bank: the edge-selector word and the sticky status byte for eight pins.
// Assumes rise/fall are already gated by a primed capture strobe.
module ped_bank (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_lo,
    input  logic                        we_hi,
    input  logic                        sts_we,
    input  logic [7:0]                  wbyte_lo,
    input  logic [7:0]                  wbyte_hi,
    input  logic [ped_pkg::PINS_PER_BANK-1:0] rise,
    input  logic [ped_pkg::PINS_PER_BANK-1:0] fall,
    output logic [ped_pkg::CFG_W-1:0]   cfg_q,
    output logic [ped_pkg::PINS_PER_BANK-1:0] sts_q
);
    import ped_pkg::*;

    logic [PINS_PER_BANK-1:0] hit;
    logic [PINS_PER_BANK-1:0] clr;

    // Per-pin match of observed edge against its selector.
    for (genvar b = 0; b < PINS_PER_BANK; b++) begin : g_pin
        pin_sel_t sel;
        assign sel    = pin_sel_t'(cfg_q[2*b +: 2]);
        assign hit[b] = (rise[b] & sel.rise_en) | (fall[b] & sel.fall_en);
    end

    assign clr = sts_we ? wbyte_lo : '0;

    // Configuration word with independent byte lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (we_lo) cfg_q[7:0]  <= wbyte_lo;
            if (we_hi) cfg_q[15:8] <= wbyte_hi;
        end
    end

    // Sticky status: write-one clears, a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr) | hit;
    end
endmodule

// File: rtl/pin_edge_evt.sv
// Top of the per-pin edge event detector: snapshot compare, bus decode, banks,
// read mux and summary interrupt. Assumes NBANKS <= 8 and ADDR_W >= 6.
module pin_edge_evt #(
    parameter int NBANKS = 8,
    parameter int ADDR_W = 6,
    localparam int NPINS = NBANKS * ped_pkg::PINS_PER_BANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_vld,
    input  logic [NPINS-1:0]  cap_data,
    input  logic              bus_wr,
    input  logic              bus_hw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq_out
);
    import ped_pkg::*;

    localparam int BW = (NBANKS > 1) ? $clog2(NBANKS) : 1;

    logic [NPINS-1:0]        rise;
    logic [NPINS-1:0]        fall;
    logic [NBANKS-1:0]       cfg_we_lo;
    logic [NBANKS-1:0]       cfg_we_hi;
    logic [NBANKS-1:0]       sts_we;
    reg_sel_t                rd_sel;
    logic [BW-1:0]           rd_bank;
    logic                    rd_hi;
    logic [7:0]              wbyte_hi;
    logic [NBANKS*CFG_W-1:0] cfg_all;
    logic [NPINS-1:0]        sts_all;

    ped_snapshot #(.NPINS(NPINS)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_vld  (cap_vld),
        .cap_data (cap_data),
        .rise     (rise),
        .fall     (fall)
    );

    ped_bus_dec #(.NBANKS(NBANKS), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_hw    (bus_hw),
        .bus_addr  (bus_addr),
        .cfg_we_lo (cfg_we_lo),
        .cfg_we_hi (cfg_we_hi),
        .sts_we    (sts_we),
        .rd_sel    (rd_sel),
        .rd_bank   (rd_bank),
        .rd_hi     (rd_hi)
    );

    // Upper config byte comes from the top lane only on halfword writes.
    assign wbyte_hi = bus_hw ? bus_wdata[15:8] : bus_wdata[7:0];

    for (genvar k = 0; k < NBANKS; k++) begin : g_bank
        ped_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_lo    (cfg_we_lo[k]),
            .we_hi    (cfg_we_hi[k]),
            .sts_we   (sts_we[k]),
            .wbyte_lo (bus_wdata[7:0]),
            .wbyte_hi (wbyte_hi),
            .rise     (rise[k*PINS_PER_BANK +: PINS_PER_BANK]),
            .fall     (fall[k*PINS_PER_BANK +: PINS_PER_BANK]),
            .cfg_q    (cfg_all[k*CFG_W +: CFG_W]),
            .sts_q    (sts_all[k*PINS_PER_BANK +: PINS_PER_BANK])
        );
    end

    // Summary interrupt over every bank.
    assign irq_out = |sts_all;

    // Combinational read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (rd_sel)
            SEL_CFG: begin
                if (bus_hw)     bus_rdata = cfg_all[int'(rd_bank)*CFG_W +: CFG_W];
                else if (rd_hi) bus_rdata = {8'h00, cfg_all[int'(rd_bank)*CFG_W + 8 +: 8]};
                else            bus_rdata = {8'h00, cfg_all[int'(rd_bank)*CFG_W +: 8]};
            end
            SEL_STS: bus_rdata = {8'h00, sts_all[int'(rd_bank)*PINS_PER_BANK +: PINS_PER_BANK]};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pin_edge_evt_chk.sv
// Property checker for pin_edge_evt, attached by bind below.
// Assumes the synchronous active-low reset is held for at least two clocks.
module pin_edge_evt_chk #(
    parameter int NBANKS = 8,
    parameter int ADDR_W = 6,
    localparam int NPINS = NBANKS * 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cap_vld,
    input logic                 bus_wr,
    input logic                 bus_hw,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 irq_out,
    input logic [NPINS-1:0]     sts_all,
    input logic [NBANKS*16-1:0] cfg_all
);
    localparam logic [ADDR_W-1:0] C_LO  = ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] C_END = ADDR_W'('h10 + 2 * NBANKS);
    localparam logic [ADDR_W-1:0] S_LO  = ADDR_W'('h20);
    localparam logic [ADDR_W-1:0] S_END = ADDR_W'('h20 + NBANKS);

    logic seen_edge = 1'b0;
    logic past_ok;
    logic primed_seen;
    logic sts_hw_wr;
    logic cfg_wr;

    // Marks that at least one clock edge has occurred.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // Tracks cycles since reset and whether a capture has happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok     <= 1'b0;
            primed_seen <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (cap_vld) primed_seen <= 1'b1;
        end
    end

    assign sts_hw_wr = bus_wr && bus_hw && (bus_addr >= S_LO) && (bus_addr < S_END);
    assign cfg_wr    = bus_wr && (bus_addr >= C_LO) && (bus_addr < C_END);

    a_r1_reset_state: assert property (@(posedge clk)
        (seen_edge && $past(!rst_n)) |-> (sts_all == '0 && cfg_all == '0 && !irq_out));

    a_r3_cfg_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(bus_wr)) |-> $stable(cfg_all));

    a_r4_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && |($past(sts_all) & ~sts_all)) |-> $past(bus_wr));

    a_r5_set_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && |(sts_all & ~$past(sts_all))) |-> $past(cap_vld));

    a_r6_first_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !primed_seen && cap_vld) |=> (sts_all == '0));

    a_r8_irq_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(irq_out)) |-> $past(cap_vld));

    a_r9_cfg_write_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cfg_wr)) |-> (($past(sts_all) & ~sts_all) == '0));

    a_r11_hw_status_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_hw_wr && !cap_vld) |=> $stable(sts_all));
endmodule

bind pin_edge_evt pin_edge_evt_chk #(.NBANKS(NBANKS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_vld  (cap_vld),
    .bus_wr   (bus_wr),
    .bus_hw   (bus_hw),
    .bus_addr (bus_addr),
    .irq_out  (irq_out),
    .sts_all  (sts_all),
    .cfg_all  (cfg_all)
);

// File: tb/pin_edge_evt_tb.sv
`timescale 1ns/1ps
module pin_edge_evt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_vld = 1'b0;
    logic [63:0] cap_data = '0;
    logic        bus_wr = 1'b0;
    logic        bus_hw = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pin_edge_evt u_dut (
        .clk(clk), .rst_n(rst_n), .cap_vld(cap_vld), .cap_data(cap_data),
        .bus_wr(bus_wr), .bus_hw(bus_hw), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    // Capture vector, then expected status of banks 0, 3, 7 and irq.
    typedef struct packed {
        logic [63:0] data;
        logic [7:0]  s0;
        logic [7:0]  s3;
        logic [7:0]  s7;
        logic        irq;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_0000, 8'h06, 8'h00, 8'h80, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'h05, 8'h01, 8'h80, 1'b1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 8'h00, 8'h00, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFF7, 8'h00, 8'h00, 8'h00, 1'b0},
        '{64'h7FFF_FFF0_FFFF_FFFF, 8'h00, 8'h00, 8'h80, 1'b1},
        '{64'h8000_0000_0000_0000, 8'h06, 8'h00, 8'h80, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Drive one cycle of inputs from a negedge; returns at the next negedge.
    task automatic step(input logic wr, input logic hw, input logic [5:0] a,
                        input logic [15:0] wd, input logic vld, input logic [63:0] d);
        bus_wr = wr; bus_hw = hw; bus_addr = a; bus_wdata = wd;
        cap_vld = vld; cap_data = d;
        @(negedge clk);
        bus_wr = 1'b0; cap_vld = 1'b0;
    endtask

    task automatic rd(input logic hw, input logic [5:0] a, output logic [15:0] v);
        bus_hw = hw; bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", irq_out, 0);
        rd(1, 6'h10, v); chk("R1 cfg0 after reset", v, 0);
        rd(0, 6'h27, v); chk("R1 sts7 after reset", v, 0);

        // R3 configuration writes and readback
        step(1, 1, 6'h10, 16'h0039, 0, cap_data);
        rd(1, 6'h10, v); chk("R3 cfg0 halfword", v, 16'h0039);
        step(1, 0, 6'h11, 16'h00AB, 0, cap_data);
        rd(1, 6'h10, v); chk("R3 cfg0 high byte write", v, 16'hAB39);
        rd(0, 6'h11, v); chk("R3 cfg0 high byte read", v, 16'h00AB);
        step(1, 0, 6'h11, 16'h0000, 0, cap_data);
        step(1, 1, 6'h16, 16'h0001, 0, cap_data);
        step(1, 1, 6'h1E, 16'hC000, 0, cap_data);
        rd(1, 6'h10, v); chk("R3 cfg0 restored", v, 16'h0039);
        rd(1, 6'h1E, v); chk("R3 cfg7 halfword", v, 16'hC000);

        // R6 first capture only primes
        step(0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R6 irq after first capture", irq_out, 0);
        rd(0, 6'h20, v); chk("R6 sts0 after first capture", v, 0);

        // R2 R10 R8 table of captures, cleared after each
        for (int i = 0; i < NV; i++) begin
            step(0, 0, 0, 0, 1, VECS[i].data);
            chk($sformatf("R8 irq vec %0d", i), irq_out, VECS[i].irq);
            rd(0, 6'h20, v); chk($sformatf("R2 sts0 vec %0d", i), v, VECS[i].s0);
            rd(0, 6'h23, v); chk($sformatf("R10 sts3 vec %0d", i), v, VECS[i].s3);
            rd(0, 6'h27, v); chk($sformatf("R10 sts7 vec %0d", i), v, VECS[i].s7);
            step(1, 0, 6'h20, 16'h00FF, 0, VECS[i].data);
            step(1, 0, 6'h23, 16'h00FF, 0, VECS[i].data);
            step(1, 0, 6'h27, 16'h00FF, 0, VECS[i].data);
            chk($sformatf("R4 irq after clear vec %0d", i), irq_out, 0);
        end

        // R5 data changes without strobe are ignored
        step(0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        step(0, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0);
        chk("R5 no strobe no irq", irq_out, 0);
        step(0, 0, 0, 0, 1, 64'h8000_0000_0000_0000);
        chk("R5 capture equal to previous", irq_out, 0);

        // R4 partial write-one clear
        step(0, 0, 0, 0, 1, 64'h8000_0000_0000_00FF);
        rd(0, 6'h20, v); chk("R5 sts0 set after capture", v, 16'h0005);
        step(1, 0, 6'h20, 16'h0001, 0, cap_data);
        rd(0, 6'h20, v); chk("R4 clear bit0 only", v, 16'h0004);
        step(1, 0, 6'h20, 16'h0000, 0, cap_data);
        rd(0, 6'h20, v); chk("R4 write zero keeps", v, 16'h0004);

        // R9 disabling config keeps status
        step(1, 1, 6'h10, 16'h0000, 0, cap_data);
        rd(0, 6'h20, v); chk("R9 sts0 kept", v, 16'h0004);
        chk("R9 irq kept", irq_out, 1);
        step(1, 1, 6'h10, 16'h0039, 0, cap_data);

        // R11 ignored accesses
        step(1, 1, 6'h20, 16'hFFFF, 0, cap_data);
        rd(0, 6'h20, v); chk("R11 halfword to status ignored", v, 16'h0004);
        step(1, 0, 6'h30, 16'h00FF, 0, cap_data);
        rd(0, 6'h30, v); chk("R11 unmapped reads zero", v, 0);
        step(1, 1, 6'h11, 16'hFFFF, 0, cap_data);
        rd(1, 6'h10, v); chk("R3 halfword at odd address ignored", v, 16'h0039);
        step(1, 0, 6'h20, 16'h00FF, 0, cap_data);
        chk("R4 bank clear drops irq", irq_out, 0);

        // R7 set wins over simultaneous clear
        step(1, 0, 6'h20, 16'h00FF, 1, 64'h8000_0000_0000_0000);
        rd(0, 6'h20, v); chk("R7 set beats clear", v, 16'h0006);
        chk("R7 irq", irq_out, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule